// File: doc/BRIEF.md
# Multi-Locality Interrupt Enable and Status Unit

This block keeps a separate interrupt enable register and interrupt status register for each of several localities (five by default) and folds them into one shared interrupt request line. Four event sources (data available, status valid, locality changed, command ready) arrive as single-cycle pulses. Each pulse carries a locality tag. A pulse is recorded in the tagged locality's status register only when that locality has its global enable and the matching source enable set. Recording an event raises the request line.

Software reaches the registers through a plain address/strobe bus. The low two address bits pick the register word and the bits above them pick the locality. Only the currently active locality, supplied from outside by the arbiter, may change its enable or status. A read-only capability word and a fixed vector word complete the register set. Status bits are write-one-to-clear. The request line is released when a clearing write empties the status of the locality it targets.

Top module: `irq_unit_top`

## Requirements
- R1: After reset every locality's enable register reads 0x0000_0008 (low-level polarity), every status register reads 0, and `irq_req` is low.
- R2: A write to the enable word keeps only bit 31 (global enable), bits 4:3 (polarity) and the source bits 0, 1, 2 and 7. Any other written bit reads back as 0, so the write mask is 0x8000_009F.
- R3: Source pulse `ev_pulse[0]` maps to status bit 0 (data available), `[1]` to bit 1 (status valid), `[2]` to bit 2 (locality changed) and `[3]` to bit 7 (command ready). A pulse tagged for locality L sets that bit in L's status, and drives `irq_req` high from the next clock edge, only when L's enable has bit 31 set and the matching source bit set.
- R4: A pulse is dropped without any effect on status or `irq_req` if the tagged locality's global enable is clear, if its source enable is clear, or if the tag is not a valid locality (5 to 7 by default).
- R5: A write to the status word clears exactly the status bits written as 1 among bits 0, 1, 2 and 7. Other status bits are untouched, and status bits never clear in any other way.
- R6: `irq_req` falls only after a status write that clears at least one set bit and leaves that locality's status at zero. If any status bit remains set, or no set bit was cleared, the line stays where it was.
- R7: Writes to the enable or status word of a locality other than `act_loc` have no effect. When `act_loc` names no valid locality, all such writes have no effect.
- R8: The capability word reads 0x0000_0097 (source mask plus bit 4, low-level support). The vector word reads the 4-bit `IRQ_VEC` parameter (0 to 15), and writes to either word are ignored.
- R9: Pulses that arrive together are all recorded in the same cycle. When a clearing status write lands in the same cycle as a pulse, the pulse is recorded first and the clear is applied after it, so a cleared bit ends at 0 and uncleared new bits stay set.
- R10: Address bits 1:0 select the word (0 enable, 1 status, 2 capability, 3 vector) and the bits above select the locality. `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_loc | input | 3 | Active locality from the arbiter; values 5 to 7 mean none |
| bus_addr | input | 5 | {locality, word} register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_pulse | input | 4 | Event pulses: data available, status valid, locality changed, command ready |
| ev_loc | input | 12 | Locality tag per source, 3 bits each, source 0 in the low bits |
| irq_req | output | 1 | Shared interrupt request, registered |

## Verification
Every locality is swept against every source under all four combinations of global enable and source enable. This separates the gating terms from each other and from the locality decode. Tags 5 to 7 with everything enabled show that invalid localities are dropped. All four pulses landing at once, and a pulse landing together with a clear of the same bit, show the set-then-clear ordering. Partial and full clears, and clears from a locality that is not active, separate "status emptied" from "any write" as the reason the line is released.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int          NUM_SRC    = 4;
  localparam logic [31:0] SRC_MASK   = 32'h0000_0087;
  localparam logic [31:0] GLB_EN     = 32'h8000_0000;
  localparam logic [31:0] POL_MASK   = 32'h0000_0018;
  localparam logic [31:0] POL_LOW    = 32'h0000_0008;
  localparam logic [31:0] CAP_LOWLVL = 32'h0000_0010;
  localparam logic [31:0] EN_WMASK   = GLB_EN | POL_MASK | SRC_MASK;
  localparam logic [31:0] CAP_VAL    = SRC_MASK | CAP_LOWLVL;

  typedef enum logic [1:0] {
    W_EN  = 2'd0,
    W_STS = 2'd1,
    W_CAP = 2'd2,
    W_VEC = 2'd3
  } reg_word_e;

  // status bit position fed by event source s
  function automatic int src_bit(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/irq_evt_route.sv
module irq_evt_route
  import irq_unit_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [NUM_SRC-1:0]            ev_pulse,
  input  logic [NUM_SRC*LOC_W-1:0]      ev_loc,
  output logic [NUM_LOC-1:0][31:0]      hit
);
  // every pulse lands on its locality; simultaneous pulses are ORed
  always_comb begin
    hit = '0;
    for (int l = 0; l < NUM_LOC; l++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (ev_pulse[s] && (ev_loc[s*LOC_W +: LOC_W] == LOC_W'(l)))
          hit[l][src_bit(s)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_loc_regs.sv
module irq_loc_regs
  import irq_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we_en,
  input  logic        we_sts,
  input  logic [31:0] wdata,
  input  logic [31:0] hit,
  output logic [31:0] en_q,
  output logic [31:0] sts_q,
  output logic        latch_any,
  output logic        release_req
);
  logic [31:0] latched, sts_set, sts_clr, sts_n;

  always_comb begin
    latched     = en_q[31] ? (hit & en_q & SRC_MASK) : '0;
    sts_set     = sts_q | latched;           // events first
    sts_clr     = wdata & SRC_MASK;
    sts_n       = we_sts ? (sts_set & ~sts_clr) : sts_set;  // then clear
    latch_any   = |latched;
    release_req = we_sts && (|(sts_clr & sts_set)) && (sts_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= POL_LOW;
      sts_q <= '0;
    end else begin
      if (we_en) en_q <= wdata & EN_WMASK;
      sts_q <= sts_n;
    end
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] set_v,
  input  logic [NUM_LOC-1:0] rel_v,
  output logic               irq_q
);
  // a new event wins over a release in the same cycle
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|set_v) | (irq_q & ~(|rel_v));
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_unit_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter int         LOC_W   = 3,
  parameter logic [3:0] IRQ_VEC = 4'd5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [LOC_W-1:0]         loc,
  input  logic [1:0]               word,
  input  logic [NUM_LOC-1:0][31:0] en_all,
  input  logic [NUM_LOC-1:0][31:0] sts_all,
  output logic [31:0]              rd_data
);
  logic        loc_ok;
  logic [31:0] sel;

  always_comb begin
    loc_ok = ({1'b0, loc} < (LOC_W+1)'(NUM_LOC));
    sel    = '0;
    case (reg_word_e'(word))
      W_EN:    if (loc_ok) sel = en_all[loc];
      W_STS:   if (loc_ok) sel = sts_all[loc];
      W_CAP:   sel = CAP_VAL;
      default: sel = {28'd0, IRQ_VEC};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/irq_unit_top.sv
module irq_unit_top
  import irq_unit_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter logic [3:0] IRQ_VEC = 4'd5,
  localparam int        LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int        ADDR_W  = LOC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LOC_W-1:0]         act_loc,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_SRC-1:0]       ev_pulse,
  input  logic [NUM_SRC*LOC_W-1:0] ev_loc,
  output logic                     irq_req
);
  logic [LOC_W-1:0]         a_loc;
  logic [1:0]               a_word;
  logic                     wr_ok;
  logic [NUM_LOC-1:0][31:0] hit, en_all, sts_all;
  logic [NUM_LOC-1:0]       set_v, rel_v;

  assign a_loc  = bus_addr[ADDR_W-1:2];
  assign a_word = bus_addr[1:0];
  assign wr_ok  = bus_wr && ({1'b0, a_loc} < (LOC_W+1)'(NUM_LOC)) && (a_loc == act_loc);

  irq_evt_route #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_route (
    .ev_pulse (ev_pulse),
    .ev_loc   (ev_loc),
    .hit      (hit)
  );

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
    logic sel_here;
    assign sel_here = wr_ok && (a_loc == LOC_W'(l));
    irq_loc_regs u_regs (
      .clk         (clk),
      .rst         (rst),
      .we_en       (sel_here && (a_word == W_EN)),
      .we_sts      (sel_here && (a_word == W_STS)),
      .wdata       (bus_wdata),
      .hit         (hit[l]),
      .en_q        (en_all[l]),
      .sts_q       (sts_all[l]),
      .latch_any   (set_v[l]),
      .release_req (rel_v[l])
    );
  end

  irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk   (clk),
    .rst   (rst),
    .set_v (set_v),
    .rel_v (rel_v),
    .irq_q (irq_req)
  );

  irq_rd_port #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_VEC(IRQ_VEC)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .loc     (a_loc),
    .word    (a_word),
    .en_all  (en_all),
    .sts_all (sts_all),
    .rd_data (bus_rdata)
  );
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter logic [3:0] IRQ_VEC = 4'd5,
  parameter int         LOC_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [LOC_W-1:0]         act_loc,
  input logic [LOC_W+1:0]         bus_addr,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [31:0]              bus_rdata,
  input logic [NUM_SRC-1:0]       ev_pulse,
  input logic                     irq_req,
  input logic [NUM_LOC-1:0][31:0] en_all,
  input logic [NUM_LOC-1:0][31:0] sts_all
);
  logic bad_en, bad_sts, own_en_wr, own_sts_wr;

  always_comb begin
    bad_en  = 1'b0;
    bad_sts = 1'b0;
    for (int l = 0; l < NUM_LOC; l++) begin
      bad_en  = bad_en  | (|(en_all[l]  & ~EN_WMASK));
      bad_sts = bad_sts | (|(sts_all[l] & ~SRC_MASK));
    end
    own_en_wr  = bus_wr && (bus_addr[1:0] == 2'd0) && (bus_addr[LOC_W+1:2] == act_loc);
    own_sts_wr = bus_wr && (bus_addr[1:0] == 2'd1) && (bus_addr[LOC_W+1:2] == act_loc);
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq_req && sts_all == '0));
  a_r2_en_masked:   assert property (@(posedge clk) disable iff (rst) !bad_en);
  a_r5_sts_sup:     assert property (@(posedge clk) disable iff (rst) !bad_sts);
  a_r3_rise_cause:  assert property (@(posedge clk) disable iff (rst)
                      $rose(irq_req) |-> $past(|ev_pulse));
  a_r6_fall_cause:  assert property (@(posedge clk) disable iff (rst)
                      $fell(irq_req) |-> $past(own_sts_wr));
  a_r7_en_guarded:  assert property (@(posedge clk) disable iff (rst)
                      !own_en_wr |=> $stable(en_all));
  a_r5_sts_sticky:  assert property (@(posedge clk) disable iff (rst)
                      !own_sts_wr |=> ((sts_all & $past(sts_all)) == $past(sts_all)));
  a_r8_vec_read:    assert property (@(posedge clk) disable iff (rst)
                      (bus_rd && bus_addr[1:0] == 2'd3) |=> (bus_rdata == {28'd0, IRQ_VEC}));
endmodule

bind irq_unit_top irq_unit_chk #(.NUM_LOC(NUM_LOC), .IRQ_VEC(IRQ_VEC), .LOC_W(LOC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .act_loc   (act_loc),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ev_pulse  (ev_pulse),
  .irq_req   (irq_req),
  .en_all    (en_all),
  .sts_all   (sts_all)
);

// File: tb/test_irq_unit_top.sv
module test_irq_unit_top;
  localparam int NL = 5;
  localparam logic [31:0] EN_M = 32'h8000_009F;
  localparam logic [31:0] SM   = 32'h0000_0087;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  act_loc = 3'd7;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  ev_pulse = '0;
  logic [11:0] ev_loc = '0;
  logic        irq_req;

  int n_tests = 0, n_fail = 0, cyc_cnt = 0, cur_act = 7;
  logic [31:0] exp_en [NL];
  logic [31:0] exp_sts[NL];
  logic        exp_irq = 1'b0;

  always #10 clk = ~clk;

  irq_unit_top #(.NUM_LOC(5), .IRQ_VEC(4'd9)) i_irq_unit_top (
    .clk(clk), .rst(rst), .act_loc(act_loc), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_pulse(ev_pulse), .ev_loc(ev_loc), .irq_req(irq_req)
  );

  function automatic int sb(int s);
    return (s == 3) ? 7 : s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one bus/event cycle with model update (events use old enables, then write)
  task automatic cyc(logic [3:0] p, int el, bit do_wr, int l, int w, logic [31:0] d);
    bit set_any = 0, rel = 0;
    logic [31:0] clr;
    @(negedge clk);
    ev_pulse = p;
    ev_loc   = {4{3'(el)}};
    bus_wr   = do_wr;
    bus_addr = {3'(l), 2'(w)};
    bus_wdata = d;
    if (el < NL && exp_en[el][31])
      for (int s = 0; s < 4; s++)
        if (p[s] && exp_en[el][sb(s)]) begin
          exp_sts[el][sb(s)] = 1'b1;
          set_any = 1;
        end
    if (do_wr && l == cur_act && l < NL) begin
      if (w == 0) exp_en[l] = d & EN_M;
      if (w == 1) begin
        clr = d & SM;
        rel = ((clr & exp_sts[l]) != 0);
        exp_sts[l] = exp_sts[l] & ~clr;
        rel = rel && (exp_sts[l] == 0);
      end
    end
    exp_irq = set_any | (exp_irq & !rel);
    @(negedge clk);
    ev_pulse = '0;
    bus_wr   = 1'b0;
  endtask

  task automatic wr(int l, int w, logic [31:0] d);
    cyc(4'b0, 0, 1, l, w, d);
  endtask

  task automatic ev(logic [3:0] p, int el);
    cyc(p, el, 0, 0, 0, 0);
  endtask

  task automatic rd(int l, int w, output logic [31:0] v);
    @(negedge clk);
    bus_addr = {3'(l), 2'(w)};
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic set_act(int l);
    @(negedge clk);
    act_loc = 3'(l);
    cur_act = l;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, hold;
    for (int l = 0; l < NL; l++) begin exp_en[l] = 32'h8; exp_sts[l] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq_req}, 0);
    for (int l = 0; l < NL; l++) begin
      rd(l, 0, v); chk("R1 enable", v, 32'h8);
      rd(l, 1, v); chk("R1 status", v, 0);
    end

    // R8 capability and vector, writes ignored
    set_act(1);
    wr(1, 2, 32'hFFFF_FFFF); wr(1, 3, 32'h0);
    rd(1, 2, v); chk("R8 cap", v, 32'h97);
    rd(1, 3, v); chk("R8 vector", v, 32'h9);

    // R7 no active locality
    set_act(7);
    wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 0, v); chk("R7 none active", v, exp_en[0]);

    // R2/R7 sweep over localities
    for (int l = 0; l < NL; l++) begin
      int o = (l + 1) % NL;
      set_act(l);
      wr(o, 0, 32'h7FFF_FF00 ^ 32'(l));
      rd(o, 0, v); chk("R7 other enable", v, exp_en[o]);
      wr(l, 0, 32'hFFFF_FFFF ^ (32'h1 << l));
      rd(l, 0, v); chk("R2 enable mask", v, (32'hFFFF_FFFF ^ (32'h1 << l)) & EN_M);
    end

    // R3/R4 sweep: locality x source x global x source enable
    for (int l = 0; l < NL; l++) begin
      set_act(l);
      for (int s = 0; s < 4; s++)
        for (int g = 0; g < 2; g++)
          for (int se = 0; se < 2; se++) begin
            wr(l, 0, (32'(g) << 31) | (32'(se) << sb(s)) | 32'h8);
            wr(l, 1, 32'hFFFF_FFFF);
            chk("R6 cleared", {31'd0, irq_req}, {31'd0, exp_irq});
            ev(4'b1 << s, l);
            chk((g && se) ? "R3 irq" : "R4 irq", {31'd0, irq_req}, {31'd0, exp_irq});
            rd(l, 1, v);
            chk((g && se) ? "R3 status" : "R4 status", v,
                (g && se) ? (32'h1 << sb(s)) : 32'h0);
          end
      wr(l, 1, 32'hFFFF_FFFF);
    end

    // R4 invalid locality tags
    set_act(4);
    wr(4, 0, 32'hFFFF_FFFF);
    for (int t = 5; t < 8; t++) begin
      ev(4'hF, t);
      chk("R4 bad tag irq", {31'd0, irq_req}, 0);
    end
    for (int l = 0; l < NL; l++) begin
      rd(l, 1, v); chk("R4 bad tag status", v, 0);
    end

    // R9 simultaneous events, R5/R6 partial and full clears
    set_act(2);
    wr(2, 0, 32'h8000_0087);
    ev(4'hF, 2);
    rd(2, 1, v); chk("R9 all sources", v, 32'h87);
    wr(2, 1, 32'h0000_0001);
    rd(2, 1, v); chk("R5 partial clear", v, 32'h86);
    chk("R6 stays high", {31'd0, irq_req}, 1);
    wr(2, 1, 32'h0000_0000);
    chk("R6 no-op write", {31'd0, irq_req}, 1);
    wr(2, 1, 32'h0000_0086);
    rd(2, 1, v); chk("R5 full clear", v, 0);
    chk("R6 released", {31'd0, irq_req}, 0);

    // R9 set and clear of the same bit in one cycle
    cyc(4'b1010, 2, 1, 2, 1, 32'h0000_0002);
    rd(2, 1, v); chk("R9 set-then-clear", v, 32'h80);
    chk("R9 irq", {31'd0, irq_req}, 1);

    // R7 clear from non-active locality ignored
    set_act(0);
    wr(2, 1, 32'hFFFF_FFFF);
    rd(2, 1, v); chk("R7 status guarded", v, 32'h80);
    chk("R7 irq kept", {31'd0, irq_req}, 1);
    set_act(2);
    wr(2, 1, 32'h80);
    chk("R6 final release", {31'd0, irq_req}, 0);

    // R10 registered read holds without strobe
    rd(2, 0, hold);
    @(negedge clk); bus_addr = {3'd2, 2'd2};
    @(negedge clk);
    chk("R10 hold", bus_rdata, hold);
    rd(2, 2, v); chk("R10 word select", v, 32'h97);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule